// File: doc/BRIEF.md
# Glitch-Free Stream/Raw Output Selector

This block drives one data output from one of two sources. The first is a stream of samples that arrives as data with a valid strobe, usually fed by a DMA engine. The second is a raw word that software writes. Software asks for the raw word by setting an overwrite-enable input. The block does not use that request bit to steer the output directly. A registered source select steers it, and that select moves only when the conditions for the switch are met.

The two switches use different conditions. A move from raw to stream waits until the stream offers a valid sample. A move from stream to raw happens as soon as overwrite is requested, whatever the valid strobe is doing. A holding register keeps the most recent stream sample, so the output stays steady between strobes.

While overwrite is requested, the holding register is loaded with the raw word. As a result, the last sample of one stream transfer can never show at the output when the next transfer begins. The output itself is registered.

Top module: `strm_raw_sel`

## Requirements
- R1: While rst_n is low, out_data is 0. After reset the block is in raw mode: with ovr_en=0 and strm_vld=0, out_data equals the raw_data sampled at the previous rising edge.
- R2: In raw mode, the block switches to stream mode only at an edge where strm_vld=1 and ovr_en=0. The sample presented at that edge reaches out_data at the following edge. Until that edge, out_data keeps tracking raw_data.
- R3: In stream mode with ovr_en=0, out_data shows the last sample accepted with strm_vld=1. Edges where strm_vld=0 leave it unchanged.
- R4: In stream mode, an edge with ovr_en=1 returns the block to raw mode whatever strm_vld is. From the next edge on, out_data follows raw_data.
- R5: While ovr_en=1, strm_data and strm_vld have no effect on out_data.
- R6: After an overwrite period, dropping ovr_en with strm_vld=0 keeps out_data on raw_data. The next stream output is the new sample, never the last sample of the previous transfer.
- R7: The output is registered. In raw mode, out_data takes the raw_data value one clock after it is sampled. A change of source takes effect one clock after the select register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strm_data | input | DATA_W | Stream sample |
| strm_vld | input | 1 | Stream sample valid |
| raw_data | input | DATA_W | Software-written raw word |
| ovr_en | input | 1 | Overwrite request: 1 asks for raw_data |
| out_data | output | DATA_W | Registered selected data |

## Verification
The hardest situation to reach is the stale-sample hazard. It needs four steps in order: a stream transfer that leaves a distinctive last sample, an overwrite period, a return of ovr_en to 0 while the stream is silent, and then a fresh transfer. The vector table walks through exactly that order and checks that the old sample never reappears. It also covers leaving stream mode on an edge where the valid strobe is high, and back-to-back valid samples. Directed tests then assert reset in the middle of a stream and check the return to raw mode.

// File: rtl/strm_raw_sel_pkg.sv
package strm_raw_sel_pkg;
   typedef enum logic {
      SRC_RAW  = 1'b0,
      SRC_STRM = 1'b1
   } src_e;
endpackage

// File: rtl/srs_src_ctl.sv
module srs_src_ctl
   import strm_raw_sel_pkg::*;
#(
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ovr_en,
   input  logic strm_vld,
   output src_e src_q
);
   src_e src_d;

   // raw -> stream waits for a valid sample; stream -> raw needs only the request
   always_comb begin
      src_d = src_q;
      unique case (src_q)
         SRC_RAW:  if (!ovr_en && strm_vld) src_d = SRC_STRM;
         SRC_STRM: if (ovr_en)              src_d = SRC_RAW;
         default:  src_d = SRC_RAW;
      endcase
   end

   if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) src_q <= SRC_RAW;
         else        src_q <= src_d;
   end else begin : g_srst
      always_ff @(posedge clk)
         if (!rst_n) src_q <= SRC_RAW;
         else        src_q <= src_d;
   end
endmodule

// File: rtl/srs_hold.sv
module srs_hold #(
   parameter int DATA_W    = 16,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ovr_en,
   input  logic              strm_vld,
   input  logic [DATA_W-1:0] strm_data,
   input  logic [DATA_W-1:0] raw_data,
   output logic [DATA_W-1:0] hold_q
);
   logic [DATA_W-1:0] hold_d;

   // overwrite flushes the stream holding register with the raw word
   always_comb begin
      if (ovr_en)        hold_d = raw_data;
      else if (strm_vld) hold_d = strm_data;
      else               hold_d = hold_q;
   end

   if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) hold_q <= '0;
         else        hold_q <= hold_d;
   end else begin : g_srst
      always_ff @(posedge clk)
         if (!rst_n) hold_q <= '0;
         else        hold_q <= hold_d;
   end
endmodule

// File: rtl/srs_out.sv
module srs_out
   import strm_raw_sel_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  src_e              src_q,
   input  logic [DATA_W-1:0] hold_q,
   input  logic [DATA_W-1:0] raw_data,
   output logic [DATA_W-1:0] out_q
);
   logic [DATA_W-1:0] mux_d;

   assign mux_d = (src_q == SRC_STRM) ? hold_q : raw_data;

   if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) out_q <= '0;
         else        out_q <= mux_d;
   end else begin : g_srst
      always_ff @(posedge clk)
         if (!rst_n) out_q <= '0;
         else        out_q <= mux_d;
   end
endmodule

// File: rtl/strm_raw_sel.sv
module strm_raw_sel
   import strm_raw_sel_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] strm_data,
   input  logic              strm_vld,
   input  logic [DATA_W-1:0] raw_data,
   input  logic              ovr_en,
   output logic [DATA_W-1:0] out_data
);
   localparam int MAX_W = 1024;

   if (DATA_W < 1 || DATA_W > MAX_W) begin : g_bad_width
      $error("strm_raw_sel: DATA_W out of range");
   end

   src_e              src_q;
   logic [DATA_W-1:0] hold_q;

   srs_src_ctl #(.ASYNC_RST(ASYNC_RST)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovr_en   (ovr_en),
      .strm_vld (strm_vld),
      .src_q    (src_q)
   );

   srs_hold #(.DATA_W(DATA_W), .ASYNC_RST(ASYNC_RST)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .ovr_en    (ovr_en),
      .strm_vld  (strm_vld),
      .strm_data (strm_data),
      .raw_data  (raw_data),
      .hold_q    (hold_q)
   );

   srs_out #(.DATA_W(DATA_W), .ASYNC_RST(ASYNC_RST)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_q    (src_q),
      .hold_q   (hold_q),
      .raw_data (raw_data),
      .out_q    (out_data)
   );
endmodule

// File: rtl/srs_chk.sv
module srs_chk
   import strm_raw_sel_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ovr_en,
   input logic              strm_vld,
   input logic [DATA_W-1:0] raw_data,
   input logic [DATA_W-1:0] out_data,
   input src_e              src_q,
   input logic [DATA_W-1:0] hold_q
);
   // R2: raw mode is left only on a valid sample
   p_raw_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == SRC_RAW && !strm_vld) |=> (src_q == SRC_RAW));

   // R4: overwrite leaves stream mode whatever the strobe
   p_ovr_leaves_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == SRC_STRM && ovr_en) |=> (src_q == SRC_RAW));

   // R3: stream mode without a strobe keeps the held sample
   p_hold_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && !strm_vld) |=> $stable(hold_q));

   // R5 / R6: overwrite flushes the holding register with the raw word
   p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_en |=> (hold_q == $past(raw_data)));

   // R7: raw mode output is raw_data one clock late
   p_raw_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == SRC_RAW) |=> (out_data == $past(raw_data)));
endmodule

bind strm_raw_sel srs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ovr_en   (ovr_en),
   .strm_vld (strm_vld),
   .raw_data (raw_data),
   .out_data (out_data),
   .src_q    (src_q),
   .hold_q   (hold_q)
);

// File: tb/sim_strm_raw_sel.sv
`timescale 1ns/1ps
module sim_strm_raw_sel;
   localparam int W = 8;
   localparam int NV = 21;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] strm_data = '0;
   logic         strm_vld = 1'b0;
   logic [W-1:0] raw_data = '0;
   logic         ovr_en = 1'b0;
   logic [W-1:0] out_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   strm_raw_sel #(.DATA_W(W), .ASYNC_RST(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .strm_data(strm_data), .strm_vld(strm_vld),
      .raw_data(raw_data), .ovr_en(ovr_en), .out_data(out_data)
   );

   // {ovr_en, strm_vld, raw_data, strm_data, expected out after edge, requirement}
   localparam logic [29:0] VEC [NV] = '{
      {1'b0, 1'b0, 8'h11, 8'h00, 8'h11, 4'd7},  // raw follows
      {1'b0, 1'b0, 8'h22, 8'h00, 8'h22, 4'd7},
      {1'b0, 1'b1, 8'h33, 8'hA1, 8'h33, 4'd2},  // R2: switch edge, still raw
      {1'b0, 1'b0, 8'h44, 8'hB2, 8'hA1, 4'd2},  // first stream sample
      {1'b0, 1'b0, 8'h55, 8'hC3, 8'hA1, 4'd3},  // R3: held
      {1'b0, 1'b1, 8'h66, 8'hD4, 8'hA1, 4'd3},
      {1'b0, 1'b0, 8'h77, 8'h00, 8'hD4, 4'd3},
      {1'b1, 1'b0, 8'h88, 8'hE5, 8'hD4, 4'd4},  // R4: select moves now
      {1'b1, 1'b1, 8'h99, 8'hF6, 8'h99, 4'd4},
      {1'b1, 1'b1, 8'h9A, 8'hF7, 8'h9A, 4'd5},  // R5: stream ignored
      {1'b0, 1'b0, 8'hBB, 8'h00, 8'hBB, 4'd6},
      {1'b0, 1'b0, 8'hCC, 8'h00, 8'hCC, 4'd6},  // R6: no stale D4
      {1'b0, 1'b1, 8'hDD, 8'h12, 8'hDD, 4'd2},
      {1'b0, 1'b0, 8'hEE, 8'h00, 8'h12, 4'd6},  // new sample only
      {1'b1, 1'b1, 8'h0F, 8'h34, 8'h12, 4'd4},  // leave with strobe high
      {1'b0, 1'b0, 8'h10, 8'h00, 8'h10, 4'd4},
      {1'b0, 1'b1, 8'h20, 8'h56, 8'h20, 4'd2},
      {1'b0, 1'b1, 8'h30, 8'h78, 8'h56, 4'd3},  // back-to-back samples
      {1'b0, 1'b1, 8'h40, 8'h9A, 8'h78, 4'd3},
      {1'b1, 1'b0, 8'h50, 8'h00, 8'h9A, 4'd4},
      {1'b0, 1'b0, 8'h60, 8'h00, 8'h60, 4'd7}
   };

   task automatic check(input logic [W-1:0] exp, input string req);
      n_tests++;
      if (out_data !== exp) begin
         n_fail++;
         $display("FAIL %s: out_data=%02h expected=%02h", req, out_data, exp);
      end
   endtask

   task automatic apply(input logic o, input logic v, input logic [W-1:0] r,
                        input logic [W-1:0] s);
      @(negedge clk);
      ovr_en = o; strm_vld = v; raw_data = r; strm_data = s;
   endtask

   initial begin
      // R1: output cleared during reset even with raw data present
      raw_data = 8'h5A;
      repeat (3) @(posedge clk);
      #1 check(8'h00, "R1");
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 check(8'h5A, "R1");

      foreach (VEC[i]) begin
         apply(VEC[i][29], VEC[i][28], VEC[i][27:20], VEC[i][19:12]);
         @(posedge clk);
         #1 check(VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
      end

      // R1: reset in the middle of a stream, then back in raw mode
      apply(1'b0, 1'b1, 8'h01, 8'hC7);
      @(posedge clk);
      apply(1'b0, 1'b0, 8'h02, 8'h00);
      @(posedge clk);
      #1 check(8'hC7, "R3");
      @(negedge clk) rst_n = 1'b0;
      #1 check(8'h00, "R1");
      @(negedge clk) rst_n = 1'b1;
      raw_data = 8'h3C;
      @(posedge clk);
      #1 check(8'h3C, "R1");

      // R7: raw change shows exactly one clock later
      apply(1'b0, 1'b0, 8'h7E, 8'h00);
      #1 check(8'h3C, "R7");
      @(posedge clk);
      #1 check(8'h7E, "R7");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule